// File: doc/BRIEF.md
# Level-Thresholded Request FIFO

This block is a small first-in first-out store of 32-bit words, eight entries deep, that sits between a streaming audio serializer and the system side of a chip. One side writes words through a push port and the other reads them through a pop port. The block keeps a count of the words held and turns that count into three request lines for the system side: two DMA request lines and one interrupt line. Each line has its own enable and its own 4-bit trigger level.

A single direction input sets how the three triggers compare the fill level. When the FIFO carries received data, a line fires once enough words have gathered. When it carries data to transmit, a line fires once the store has drained far enough. A registered status word gives the three request states and the fill level in one snapshot. The level goes into the receive field or the transmit field, depending on the direction. Pushing into a full store and popping from an empty one are both refused, and each refusal leaves a sticky error flag.

Top module: `lvl_req_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, `level` is 0, `empty` is 1, `full` is 0, and `pop_vld`, `dma_req`, `irq`, `status`, `ovf_err` and `udf_err` are all 0.
- R2: Words leave in the order they were accepted. An accepted pop at edge N puts the oldest word on `pop_data` with `pop_vld` high for the cycle that follows edge N.
- R3: `level` counts the stored words, from 0 to 8, and changes at the edge that accepts a push or a pop. `full` is high exactly when `level` is 8, and `empty` is high exactly when `level` is 0.
- R4: When push and pop are both high while the store is neither full nor empty, both are accepted and `level` stays the same.
- R5: A push while `full` is high is dropped: the content and `level` do not change. `ovf_err` goes high at that edge and stays high until reset. A pop in the same cycle is still accepted.
- R6: A pop while `empty` is high is dropped: `pop_vld` stays 0 in the next cycle. `udf_err` goes high at that edge and stays high until reset.
- R7: With `rx_mode`=1, a request line is high in the cycle after a cycle in which its enable is 1 and `level` >= its threshold. Otherwise it is low.
- R8: With `rx_mode`=0, a request line is high in the cycle after a cycle in which its enable is 1 and `level` <= its threshold. Otherwise it is low.
- R9: A request line whose enable bit is 0 stays low, whatever the level and the threshold.
- R10: `status` is updated in the same cycle as the request lines. Bit 0 is `irq`, bit 1 is `dma_req[0]` and bit 2 is `dma_req[1]`. Bits [6:3] hold the level when `rx_mode`=1, and bits [10:7] hold it when `rx_mode`=0. The unused level field is 0.
- R11: The slots are independent. Slot 0 (`req_en[0]`, `req_thr[3:0]`) drives `dma_req[0]`. Slot 1 (`req_en[1]`, `req_thr[7:4]`) drives `dma_req[1]`. Slot 2 (`req_en[2]`, `req_thr[11:8]`) drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_mode | input | 1 | 1: receive comparison (>=), 0: transmit comparison (<=) |
| push | input | 1 | Write request |
| push_data | input | 32 | Word to write |
| pop | input | 1 | Read request |
| pop_data | output | 32 | Word read, valid while pop_vld is high |
| pop_vld | output | 1 | pop_data holds a word popped at the previous edge |
| level | output | 4 | Number of stored words |
| full | output | 1 | Store holds 8 words |
| empty | output | 1 | Store holds no word |
| req_en | input | 3 | Enables for slot 0, 1 and 2 |
| req_thr | input | 12 | Trigger levels, 4 bits per slot, slot 0 in the low bits |
| dma_req | output | 2 | DMA request lines (slots 0 and 1) |
| irq | output | 1 | Interrupt line (slot 2) |
| status | output | 11 | Packed request states and level |
| ovf_err | output | 1 | Sticky flag for a refused push |
| udf_err | output | 1 | Sticky flag for a refused pop |

## Verification
The count, `full`, `empty`, the error flags and the popped word all change at the edge that takes the push or pop. The bench checks them one time unit after that edge. The request lines and `status` come one register later, so every request or status check follows at least one idle cycle in which the level, enables and thresholds stay the same. The popped words are compared by a monitor at the falling edge while `pop_vld` is high, against a queue that the driver fills only with pushes that its own level model accepts.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int N_SLOT    = 3;
  localparam int SLOT_DMA0 = 0;
  localparam int SLOT_DMA1 = 1;
  localparam int SLOT_IRQ  = 2;
endpackage

// File: rtl/lrf_ram.sv
module lrf_ram #(
  parameter int DW = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd <= mem[ra];
  end
endmodule

// File: rtl/lrf_ctrl.sv
module lrf_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    rd_ptr,
  output logic [LVL_W-1:0] cnt,
  output logic             full,
  output logic             empty,
  output logic             rd_vld,
  output logic             ovf,
  output logic             udf
);
  localparam logic [LVL_W-1:0] CNT_MAX = LVL_W'(DEPTH);
  localparam logic [AW-1:0]    PTR_END = AW'(DEPTH - 1);

  assign full  = (cnt == CNT_MAX);
  assign empty = (cnt == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == PTR_END) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      rd_vld <= 1'b0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + LVL_W'(1);
        2'b01:   cnt <= cnt - LVL_W'(1);
        default: cnt <= cnt;
      endcase
      rd_vld <= rd_ok;
      if (push && full) ovf <= 1'b1;
      if (pop && empty) udf <= 1'b1;
    end
  end
endmodule

// File: rtl/lrf_trig.sv
module lrf_trig #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_mode,
  input  logic             en,
  input  logic [LVL_W-1:0] thr,
  input  logic [LVL_W-1:0] level,
  output logic             hit,
  output logic             req
);
  logic cmp;

  always_comb begin
    if (rx_mode) cmp = (level >= thr);
    else         cmp = (level <= thr);
    hit = en && cmp;
  end

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= hit;
  end
endmodule

// File: rtl/lvl_req_fifo.sv
module lvl_req_fifo #(
  parameter int DW = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int NS = lrf_pkg::N_SLOT,
  localparam int ST_W = NS + 2 * LVL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_mode,
  input  logic                push,
  input  logic [DW-1:0]       push_data,
  input  logic                pop,
  output logic [DW-1:0]       pop_data,
  output logic                pop_vld,
  output logic [LVL_W-1:0]    level,
  output logic                full,
  output logic                empty,
  input  logic [NS-1:0]       req_en,
  input  logic [NS*LVL_W-1:0] req_thr,
  output logic [1:0]          dma_req,
  output logic                irq,
  output logic [ST_W-1:0]     status,
  output logic                ovf_err,
  output logic                udf_err
);
  import lrf_pkg::*;

  logic          wr_ok, rd_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [NS-1:0] hit, req;

  lrf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .cnt(level), .full(full), .empty(empty), .rd_vld(pop_vld),
    .ovf(ovf_err), .udf(udf_err)
  );

  lrf_ram #(.DW(DW), .DEPTH(DEPTH)) ram_i (
    .clk(clk), .we(wr_ok), .wa(wr_ptr), .wd(push_data),
    .re(rd_ok), .ra(rd_ptr), .rd(pop_data)
  );

  for (genvar s = 0; s < NS; s++) begin : g_slot
    lrf_trig #(.LVL_W(LVL_W)) trig_i (
      .clk(clk), .rst(rst), .rx_mode(rx_mode), .en(req_en[s]),
      .thr(req_thr[s*LVL_W +: LVL_W]), .level(level),
      .hit(hit[s]), .req(req[s])
    );
  end

  assign dma_req = {req[SLOT_DMA1], req[SLOT_DMA0]};
  assign irq     = req[SLOT_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else begin
      status <= {(rx_mode ? '0 : level), (rx_mode ? level : '0),
                 hit[SLOT_DMA1], hit[SLOT_DMA0], hit[SLOT_IRQ]};
    end
  end
endmodule

// File: rtl/lrf_chk.sv
module lrf_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_mode,
  input logic             push,
  input logic             pop,
  input logic             full,
  input logic             empty,
  input logic             pop_vld,
  input logic [LVL_W-1:0] level,
  input logic [2:0]       req_en,
  input logic [3*LVL_W-1:0] req_thr,
  input logic [1:0]       dma_req,
  input logic             irq,
  input logic [2:0]       status_lo,
  input logic             ovf_err,
  input logic             udf_err
);
  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (level <= LVL_W'(DEPTH)) && (full == (level == LVL_W'(DEPTH))));

  // R4
  pair_keep_chk: assert property (@(posedge clk) disable iff (rst)
    push && pop && !full && !empty |=> $stable(level));

  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    push && !pop && full |=> $stable(level) && ovf_err);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  // R6
  udf_drop_chk: assert property (@(posedge clk) disable iff (rst)
    pop && empty |=> !pop_vld && udf_err);

  // R6
  udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    udf_err |=> udf_err);

  // R7
  rx_fire_chk: assert property (@(posedge clk) disable iff (rst)
    rx_mode && req_en[0] && (level >= req_thr[0 +: LVL_W]) |=> dma_req[0]);

  // R8
  tx_fire_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_mode && req_en[1] && (level <= req_thr[LVL_W +: LVL_W]) |=> dma_req[1]);

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !req_en[2] |=> !irq);

  // R10
  status_bits_chk: assert property (@(posedge clk) disable iff (rst)
    status_lo == {dma_req[1], dma_req[0], irq});
endmodule

bind lvl_req_fifo lrf_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .rx_mode(rx_mode), .push(push), .pop(pop),
  .full(full), .empty(empty), .pop_vld(pop_vld), .level(level),
  .req_en(req_en), .req_thr(req_thr), .dma_req(dma_req), .irq(irq),
  .status_lo(status[2:0]), .ovf_err(ovf_err), .udf_err(udf_err)
);

// File: tb/lvl_req_fifo_tb_top.sv
module lvl_req_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_mode = 1'b1;
  logic        push = 1'b0, pop = 1'b0;
  logic [31:0] push_data = '0;
  logic [31:0] pop_data;
  logic        pop_vld, full, empty, irq, ovf_err, udf_err;
  logic [3:0]  level;
  logic [2:0]  req_en = '0;
  logic [11:0] req_thr = '0;
  logic [1:0]  dma_req;
  logic [10:0] status;

  int total = 0, bad = 0;
  int mdl_lvl = 0, pops_exp = 0, pops_got = 0;
  logic [31:0] sb[$];
  bit done = 0;

  always #4 clk = ~clk;

  lvl_req_fifo dut_i (
    .clk(clk), .rst(rst), .rx_mode(rx_mode), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .pop_vld(pop_vld), .level(level),
    .full(full), .empty(empty), .req_en(req_en), .req_thr(req_thr),
    .dma_req(dma_req), .irq(irq), .status(status),
    .ovf_err(ovf_err), .udf_err(udf_err)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares popped words against the scoreboard (R2)
  always @(negedge clk) begin
    if (!rst && pop_vld) begin
      pops_got++;
      if (sb.size() == 0) check("R2 pop with empty scoreboard", 1, 0);
      else check("R2 pop order", int'(pop_data), int'(sb.pop_front()));
    end
  end

  task automatic cyc(bit p, bit q, logic [31:0] d);
    bit wr, rd;
    wr = p && (mdl_lvl < 8);
    rd = q && (mdl_lvl > 0);
    push = p; pop = q; push_data = d;
    @(posedge clk);
    #1;
    push = 0; pop = 0;
    if (rd) begin mdl_lvl--; pops_exp++; end
    if (wr) begin mdl_lvl++; sb.push_back(d); end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0);
  endtask

  task automatic chk_req(string tag, int st);
    bit [2:0] e;
    for (int s = 0; s < 3; s++) begin
      int t = int'(req_thr[s*4 +: 4]);
      e[s] = req_en[s] && (rx_mode ? (mdl_lvl >= t) : (mdl_lvl <= t));
    end
    check({tag, " dma0"}, int'(dma_req[0]), int'(e[0]));
    check({tag, " dma1"}, int'(dma_req[1]), int'(e[1]));
    check({tag, " irq"}, int'(irq), int'(e[2]));
    check("R10 status", int'(status), st);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    // R1: reset values
    check("R1 level", int'(level), 0);
    check("R1 empty", int'(empty), 1);
    check("R1 outs", int'({full, pop_vld, dma_req, irq, ovf_err, udf_err}), 0);
    check("R1 status", int'(status), 0);
    rst = 0;

    // R7/R11: receive mode, slot thresholds 2, 5, 8
    rx_mode = 1; req_en = 3'b111; req_thr = {4'd8, 4'd5, 4'd2};
    for (int i = 0; i < 3; i++) cyc(1, 0, 32'hA000_0000 + i);
    check("R3 level", int'(level), 3);
    idle(1);
    chk_req("R7 rx lvl3", 2 + (3 << 3));
    for (int i = 3; i < 8; i++) cyc(1, 0, 32'hA000_0000 + i);
    check("R3 full", int'(full), 1);
    idle(1);
    chk_req("R7 rx full", 7 + (8 << 3));

    // R5: overflow push dropped
    cyc(1, 0, 32'hDEAD_BEEF);
    check("R5 level", int'(level), 8);
    check("R5 ovf_err", int'(ovf_err), 1);

    cyc(0, 1, '0);
    check("R3 level after pop", int'(level), 7);
    // R4: simultaneous push and pop
    cyc(1, 1, 32'hB000_0009);
    check("R4 level", int'(level), 7);

    // R8: transmit mode
    rx_mode = 0;
    idle(1);
    chk_req("R8 tx lvl7", 1 + (7 << 7));
    // R9: all disabled
    req_en = 3'b000;
    idle(1);
    chk_req("R9 off", 7 << 7);
    // R11: only slot 0, threshold 7
    req_en = 3'b001; req_thr = {4'd8, 4'd7, 4'd7};
    idle(1);
    chk_req("R11 slot0 only", 2 + (7 << 7));

    // drain
    while (mdl_lvl > 0) cyc(0, 1, '0);
    check("R3 empty", int'(empty), 1);
    // R6: underflow pop dropped
    cyc(0, 1, '0);
    check("R6 pop_vld", int'(pop_vld), 0);
    check("R6 udf_err", int'(udf_err), 1);
    check("R6 level", int'(level), 0);
    check("R5 ovf sticky", int'(ovf_err), 1);

    // boundary: level 0, threshold 0 in both modes
    req_en = 3'b010; req_thr = 12'h0;
    idle(1);
    chk_req("R8 tx zero", 4);
    rx_mode = 1;
    idle(1);
    chk_req("R7 rx zero", 4);

    idle(2);
    check("R2 pop count", pops_got, pops_exp);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule